// File: doc/BRIEF.md
# Erasable ROM Bus Mode Decoder Model

This block is a synthesizable behavioural model of a byte-wide, ultraviolet-erasable read-only memory with a small internal array. It takes four control inputs and decodes them into one of six bus modes. The inputs are an active-low select that doubles as the program strobe, an active-low output enable, a flag that stands for the programming supply, and a flag that stands for an overvoltage on address line 9. The block then serves array bytes, identifier bytes or nothing on a split tri-state data bus (value plus drive enable). When the block is in program mode, it merges the byte on the data input into the addressed cell. Analog levels are reduced to single-bit flags.

Programming can only pull bits from one to zero, because each write stores the old byte ANDed with the new one. A bulk erase input restores every cell to all ones in a single clock. Reset does the same, so a freshly reset model behaves like a blank part. Read data appears on the bus only after a configurable number of cycles with a steady address and steady controls. Until then, a driven bus carries zeros.

Top module: `eprom_mode_model`

## Requirements
- R1: With select low, output enable low, programming flag low and overvoltage flag low, `mode_o` is 1 (read), `dq_drive` is high and the settled `dq_out` equals the stored byte at `addr`.
- R2: With select high and programming flag low, `mode_o` is 0 (standby), and `dq_drive` and `dq_out` are both zero whatever the output enable does.
- R3: `dq_drive` is never high while output enable is high. With select low, programming flag low and output enable high, `mode_o` stays 1 and the bus stays undriven.
- R4: With the programming flag high, select low and output enable high, `mode_o` is 3 (program), the bus is undriven, and every rising edge stores (old byte AND `dq_in`) at `addr`.
- R5: With the programming flag high and any other select/enable pairing than program (R4) or verify (R6), `mode_o` is 4 (inhibit), the bus is undriven and no cell changes.
- R6: With the programming flag high, select high and output enable low, `mode_o` is 5 (verify), and the settled `dq_out` is the stored byte at `addr`.
- R7: With the overvoltage flag high, select low and programming flag low, `mode_o` is 2 (identifier). When output enable is low, the settled bus carries the manufacturer code for `addr[0]`=0 and the device code for `addr[0]`=1. Bit 7 of each code is chosen so that the byte has an odd number of ones over bits 6..0 of the code parameter.
- R8: One rising edge with `erase` high sets every cell to FFh, and it overrides a program write on that edge. Reset also leaves every cell at FFh.
- R9: After any change of `addr` or of the four control flags, a driven `dq_out` reads zero until LAT+1 rising edges have passed with those inputs unchanged. From then on it carries the selected byte. `dq_drive` follows the mode without delay.
- R10: Programming a byte that is already stored, or programming FFh, leaves the cell unchanged, however many edges the program mode is held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; blanks the array |
| ce_pgm_n | input | 1 | Active-low select, also the program strobe |
| oe_n | input | 1 | Active-low output enable |
| vpp_on | input | 1 | Programming supply present |
| a9_hv | input | 1 | Overvoltage on address line 9 |
| erase | input | 1 | Bulk erase to all ones |
| addr | input | ADDR_W | Byte address |
| dq_in | input | 8 | Bus value seen by the block (program data) |
| dq_out | output | 8 | Bus value driven by the block |
| dq_drive | output | 1 | High when the block drives the bus |
| mode_o | output | 3 | Decoded mode: 0 standby, 1 read, 2 identifier, 3 program, 4 inhibit, 5 verify |

## Verification
The embedded properties check these rules on every cycle: no drive with output enable high or in standby or program, an undriven bus always reads zero, a program edge only clears bits, a non-program edge leaves the addressed cell alone, erase fills the array, and driven identifier bytes have odd parity. Whether the right byte appears, whether the manufacturer and device codes are swapped, and in exactly which cycle the data becomes valid can only be shown by the bench. The bench does this with full address sweeps after layered programming, the sixteen control combinations, and edge-by-edge sampling around an address or enable change.

// File: rtl/eprom_pkg.sv
package eprom_pkg;

    typedef enum logic [2:0] {
        MODE_STANDBY = 3'd0,
        MODE_READ    = 3'd1,
        MODE_IDENT   = 3'd2,
        MODE_PROGRAM = 3'd3,
        MODE_INHIBIT = 3'd4,
        MODE_VERIFY  = 3'd5
    } bus_mode_e;

    typedef struct packed {
        logic sel_n;
        logic out_n;
        logic vpp;
        logic hv;
    } ctrl_pins_t;

    typedef struct packed {
        bus_mode_e mode;
        logic      drive;
        logic      wr;
        logic      ident;
    } decode_t;

    function automatic logic [7:0] with_odd_parity(input logic [6:0] v);
        return {~(^v), v};
    endfunction

    function automatic decode_t decode_pins(input ctrl_pins_t p);
        decode_t d;
        d.mode  = MODE_STANDBY;
        d.drive = 1'b0;
        d.wr    = 1'b0;
        d.ident = 1'b0;
        if (p.vpp) begin
            if (!p.sel_n && p.out_n) begin
                d.mode = MODE_PROGRAM;
                d.wr   = 1'b1;
            end else if (p.sel_n && !p.out_n) begin
                d.mode  = MODE_VERIFY;
                d.drive = 1'b1;
            end else begin
                d.mode = MODE_INHIBIT;
            end
        end else if (!p.sel_n) begin
            d.drive = !p.out_n;
            if (p.hv) begin
                d.mode  = MODE_IDENT;
                d.ident = 1'b1;
            end else begin
                d.mode = MODE_READ;
            end
        end
        return d;
    endfunction

endpackage

// File: rtl/eprom_mode_decode.sv
module eprom_mode_decode
    import eprom_pkg::*;
(
    input  ctrl_pins_t pins_i,
    output decode_t    dec_o
);

    always_comb begin
        dec_o = decode_pins(pins_i);
    end

endmodule

// File: rtl/eprom_settle_timer.sv
module eprom_settle_timer #(
    parameter int CW  = 8,
    parameter int LAT = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] cur_i,
    output logic          settled_o
);

    localparam int CNT_W = (LAT < 1) ? 1 : $clog2(LAT + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(LAT);

    logic [CW-1:0]    snap_q;
    logic [CNT_W-1:0] cnt_q;
    logic             same;

    assign same = (cur_i == snap_q);

    always_ff @(posedge clk) begin
        snap_q <= cur_i;
        if (rst || !same) begin
            cnt_q <= '0;
        end else if (cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign settled_o = same && (cnt_q == CNT_MAX);

    // R9
    timer_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_MAX);

    // R9
    settle_stable_chk: assert property (@(posedge clk) disable iff (rst)
        settled_o |-> (cur_i == $past(cur_i)));

endmodule

// File: rtl/eprom_cell_array.sv
module eprom_cell_array #(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              erase_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        wr_data_i,
    output logic [7:0]        rd_data_o
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem [DEPTH];
    logic       blank;
    logic       merge;

    assign blank = rst || erase_i;
    assign merge = wr_i && !erase_i;

    always_ff @(posedge clk) begin
        if (blank) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= 8'hFF;
            end
        end else if (merge) begin
            mem[addr_i] <= mem[addr_i] & wr_data_i;
        end
    end

    assign rd_data_o = mem[addr_i];

    // R10
    clear_only_chk: assert property (@(posedge clk) disable iff (rst)
        merge |=> ((mem[$past(addr_i)] & ~$past(mem[addr_i])) == 8'h00));

    // R5
    inhibit_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!wr_i && !erase_i) |=> (mem[$past(addr_i)] == $past(mem[addr_i])));

    // R8
    erase_fill_chk: assert property (@(posedge clk) disable iff (rst)
        erase_i |=> ((mem[0] == 8'hFF) && (mem[DEPTH-1] == 8'hFF)
                     && (mem[$past(addr_i)] == 8'hFF)));

endmodule

// File: rtl/eprom_mode_model.sv
module eprom_mode_model
    import eprom_pkg::*;
#(
    parameter int           ADDR_W    = 6,
    parameter int           LAT       = 2,
    parameter logic [6:0]   MFR_CODE7 = 7'h01,
    parameter logic [6:0]   DEV_CODE7 = 7'h0F
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_pgm_n,
    input  logic              oe_n,
    input  logic              vpp_on,
    input  logic              a9_hv,
    input  logic              erase,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        dq_in,
    output logic [7:0]        dq_out,
    output logic              dq_drive,
    output logic [2:0]        mode_o
);

    localparam int CW = ADDR_W + $bits(ctrl_pins_t);
    localparam logic [7:0] MFR_BYTE = with_odd_parity(MFR_CODE7);
    localparam logic [7:0] DEV_BYTE = with_odd_parity(DEV_CODE7);

    ctrl_pins_t pins;
    decode_t    dec;
    logic       settled;
    logic [7:0] cell_byte;
    logic [7:0] id_byte;
    logic [7:0] sel_byte;

    assign pins = '{sel_n: ce_pgm_n, out_n: oe_n, vpp: vpp_on, hv: a9_hv};

    eprom_mode_decode u_decode (
        .pins_i (pins),
        .dec_o  (dec)
    );

    eprom_settle_timer #(
        .CW  (CW),
        .LAT (LAT)
    ) u_timer (
        .clk       (clk),
        .rst       (rst),
        .cur_i     ({addr, pins}),
        .settled_o (settled)
    );

    eprom_cell_array #(
        .ADDR_W (ADDR_W)
    ) u_array (
        .clk       (clk),
        .rst       (rst),
        .erase_i   (erase),
        .wr_i      (dec.wr),
        .addr_i    (addr),
        .wr_data_i (dq_in),
        .rd_data_o (cell_byte)
    );

    assign id_byte  = addr[0] ? DEV_BYTE : MFR_BYTE;
    assign sel_byte = dec.ident ? id_byte : cell_byte;

    assign dq_drive = dec.drive;
    assign dq_out   = (dec.drive && settled) ? sel_byte : 8'h00;
    assign mode_o   = dec.mode;

    // R2
    standby_hiz_chk: assert property (@(posedge clk) disable iff (rst)
        (ce_pgm_n && !vpp_on) |-> (!dq_drive && (dq_out == 8'h00)));

    // R3
    drive_needs_oe_chk: assert property (@(posedge clk) disable iff (rst)
        dq_drive |-> !oe_n);

    // R4
    program_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 3'd3) |-> !dq_drive);

    // R9
    undriven_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !dq_drive |-> (dq_out == 8'h00));

    // R7
    id_parity_chk: assert property (@(posedge clk) disable iff (rst)
        ((mode_o == 3'd2) && (dq_out != 8'h00)) |-> (^dq_out));

endmodule

// File: tb/eprom_mode_model_tb.sv
module eprom_mode_model_tb_top;

    localparam int AW    = 4;
    localparam int DEPTH = 1 << AW;
    localparam int LAT   = 2;
    localparam logic [6:0] MFR7 = 7'h23;
    localparam logic [6:0] DEV7 = 7'h4D;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ce = 1'b1, oe = 1'b1, vpp = 1'b0, hv = 1'b0, er = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    din = 8'hFF;
    logic [7:0]    dq_out;
    logic          dq_drive;
    logic [2:0]    mode_o;
    logic [7:0]    model [DEPTH];
    int            checks = 0;
    int            fails  = 0;
    logic          done   = 1'b0;

    always #4 clk = ~clk;

    eprom_mode_model #(
        .ADDR_W    (AW),
        .LAT       (LAT),
        .MFR_CODE7 (MFR7),
        .DEV_CODE7 (DEV7)
    ) dut_i (
        .clk      (clk),
        .rst      (rst),
        .ce_pgm_n (ce),
        .oe_n     (oe),
        .vpp_on   (vpp),
        .a9_hv    (hv),
        .erase    (er),
        .addr     (addr),
        .dq_in    (din),
        .dq_out   (dq_out),
        .dq_drive (dq_drive),
        .mode_o   (mode_o)
    );

    function automatic logic [2:0] exp_mode(logic c, logic o, logic v, logic h);
        if (v) begin
            if (!c && o) return 3'd3;
            if (c && !o) return 3'd5;
            return 3'd4;
        end
        if (c) return 3'd0;
        if (h) return 3'd2;
        return 3'd1;
    endfunction

    function automatic logic exp_drive(logic c, logic o, logic v);
        if (v) return c && !o;
        return !c && !o;
    endfunction

    function automatic logic [7:0] id_code(logic [6:0] v);
        int n = 0;
        for (int i = 0; i < 7; i++) n += int'(v[i]);
        return {((n % 2) == 0) ? 1'b1 : 1'b0, v};
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%02h expected=%02h", req, what, act, exp);
        end
    endtask

    task automatic set_pins(input logic c, input logic o, input logic v, input logic h,
                            input logic [AW-1:0] a, input logic [7:0] d, input logic e);
        @(negedge clk);
        ce = c; oe = o; vpp = v; hv = h; addr = a; din = d; er = e;
    endtask

    task automatic settle();
        repeat (LAT + 1) @(posedge clk);
        #1;
    endtask

    task automatic prog(input logic [AW-1:0] a, input logic [7:0] d, input int n);
        set_pins(1'b0, 1'b1, 1'b1, 1'b0, a, d, 1'b0);
        #1;
        chk("R4", "program mode", {5'b0, mode_o}, 8'd3);
        chk("R4", "program undriven", {7'b0, dq_drive}, 8'd0);
        repeat (n) @(posedge clk);
        model[a] = model[a] & d;
    endtask

    task automatic read_all(input string req, input logic c, input logic o, input logic v);
        for (int a = 0; a < DEPTH; a++) begin
            set_pins(c, o, v, 1'b0, AW'(a), 8'hFF, 1'b0);
            settle();
            chk(req, "array byte", dq_out, model[a]);
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int a = 0; a < DEPTH; a++) model[a] = 8'hFF;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R2 reset state: standby
        chk("R2", "reset mode", {5'b0, mode_o}, 8'd0);
        chk("R2", "reset drive", {7'b0, dq_drive}, 8'd0);
        chk("R2", "reset bus", dq_out, 8'h00);

        // R8 reset leaves blank array; R1 read sweep
        read_all("R8", 1'b0, 1'b0, 1'b0);

        // R4 program first pattern
        for (int a = 0; a < DEPTH; a++) prog(AW'(a), 8'(a * 37 + 5), 1);
        read_all("R1", 1'b0, 1'b0, 1'b0);

        // R4 second pattern over the first; R10 repeated pulses on odd cells
        for (int a = 0; a < DEPTH; a++)
            prog(AW'(a), 8'(a * 11) ^ 8'hA5, (a % 2 == 1) ? 3 : 1);
        read_all("R6", 1'b1, 1'b0, 1'b1);

        // R10 FFh and same byte leave cells alone
        prog(AW'(3), 8'hFF, 2);
        prog(AW'(7), model[7], 4);
        read_all("R10", 1'b0, 1'b0, 1'b0);

        // R5 inhibit pairings with zero data
        for (int a = 0; a < DEPTH; a++) begin
            set_pins(1'b1, 1'b1, 1'b1, 1'b0, AW'(a), 8'h00, 1'b0);
            #1;
            chk("R5", "inhibit mode", {5'b0, mode_o}, 8'd4);
            chk("R5", "inhibit undriven", {7'b0, dq_drive}, 8'd0);
            repeat (2) @(posedge clk);
            set_pins(1'b0, 1'b0, 1'b1, 1'b0, AW'(a), 8'h00, 1'b0);
            #1;
            chk("R5", "inhibit mode lowlow", {5'b0, mode_o}, 8'd4);
            repeat (2) @(posedge clk);
        end
        read_all("R5", 1'b0, 1'b0, 1'b0);

        // R2 standby ignores output enable; R3 output disable
        for (int o = 0; o < 2; o++) begin
            set_pins(1'b1, 1'(o), 1'b0, 1'b0, AW'(9), 8'hFF, 1'b0);
            settle();
            chk("R2", "standby mode", {5'b0, mode_o}, 8'd0);
            chk("R2", "standby drive", {7'b0, dq_drive}, 8'd0);
            chk("R2", "standby bus", dq_out, 8'h00);
        end
        set_pins(1'b0, 1'b1, 1'b0, 1'b0, AW'(9), 8'hFF, 1'b0);
        settle();
        chk("R3", "disable mode", {5'b0, mode_o}, 8'd1);
        chk("R3", "disable drive", {7'b0, dq_drive}, 8'd0);
        chk("R3", "disable bus", dq_out, 8'h00);

        // R7 identifier bytes over all addresses
        for (int a = 0; a < DEPTH; a++) begin
            set_pins(1'b0, 1'b0, 1'b0, 1'b1, AW'(a), 8'hFF, 1'b0);
            settle();
            chk("R7", "ident mode", {5'b0, mode_o}, 8'd2);
            chk("R7", "ident byte", dq_out, (a % 2 == 1) ? id_code(DEV7) : id_code(MFR7));
        end

        // R8 erase overrides a zero program write
        set_pins(1'b0, 1'b1, 1'b1, 1'b0, AW'(4), 8'h00, 1'b1);
        @(posedge clk);
        set_pins(1'b1, 1'b1, 1'b0, 1'b0, AW'(0), 8'hFF, 1'b0);
        for (int a = 0; a < DEPTH; a++) model[a] = 8'hFF;
        read_all("R8", 1'b0, 1'b0, 1'b0);

        // R9 latency after an address change and after an enable change
        prog(AW'(6), 8'h5A, 1);
        set_pins(1'b0, 1'b0, 1'b0, 1'b0, AW'(5), 8'hFF, 1'b0);
        settle();
        set_pins(1'b0, 1'b0, 1'b0, 1'b0, AW'(6), 8'hFF, 1'b0);
        #1;
        chk("R9", "drive immediate", {7'b0, dq_drive}, 8'd1);
        chk("R9", "zero before edge", dq_out, 8'h00);
        for (int k = 0; k < LAT; k++) begin
            @(posedge clk); #1;
            chk("R9", "zero while settling", dq_out, 8'h00);
        end
        @(posedge clk); #1;
        chk("R9", "valid after settle", dq_out, 8'h5A);
        set_pins(1'b0, 1'b1, 1'b0, 1'b0, AW'(6), 8'hFF, 1'b0);
        set_pins(1'b0, 1'b0, 1'b0, 1'b0, AW'(6), 8'hFF, 1'b0);
        for (int k = 0; k < LAT; k++) begin
            @(posedge clk); #1;
            chk("R9", "zero after enable", dq_out, 8'h00);
        end
        @(posedge clk); #1;
        chk("R9", "valid after enable", dq_out, 8'h5A);

        // All sixteen control combinations at address 6, FFh data
        for (int m = 0; m < 16; m++) begin
            logic c, o, v, h;
            logic [7:0] e;
            c = m[3]; o = m[2]; v = m[1]; h = m[0];
            set_pins(c, o, v, h, AW'(6), 8'hFF, 1'b0);
            settle();
            chk("R1", "sweep mode", {5'b0, mode_o}, {5'b0, exp_mode(c, o, v, h)});
            chk("R3", "sweep drive", {7'b0, dq_drive}, {7'b0, exp_drive(c, o, v)});
            e = 8'h00;
            if (exp_drive(c, o, v)) e = (!v && h) ? id_code(MFR7) : model[6];
            chk("R6", "sweep bus", dq_out, e);
        end
        read_all("R10", 1'b0, 1'b0, 1'b0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule